// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of an in-system serial programming link. It drives the target's reset line, a serial clock and a serial data line toward the target, and it samples the target's serial output. After a start pulse it gives the target a reset pulse and waits out the power-up delay. It then sends the enable frame and checks the echo byte. If the echo is wrong it resynchronises with a new reset pulse and tries again, and it gives up after a set number of tries.

Once enabled, the block programs flash pages one after another. The words come from a valid/ready stream. Each word is sent as a low-byte load followed by a high-byte load. Each page is committed with a write frame. After each commit the block either polls the target's status until it is idle, or waits a fixed number of host clocks. The extended address frame is sent before the first page, and again only when the upper address byte changes.

Every frame is four bytes, sent MSB first. Opcodes: enable 0xAC 0x53 0x00 0x00, extended address 0x4D, load low 0x40, load high 0x48, commit 0x4C, status poll 0xF0.

Word stream rules: `wd_ready_o` is high only while the sequencer waits for the next word. A word is taken on a clock edge where both `wd_valid_i` and `wd_ready_o` are high. The producer may hold valid low for as long as it likes, and the link stays idle meanwhile. `wd_last_i` marks the final word of the session.

Top module: `isp_host_seq`

## Requirements
- R1: During and right after reset, the following outputs are all 0: `done_o`, `err_o`, `retries_o`, `tgt_rst_o`, `tgt_sck_o` and `wd_ready_o`.
- R2: After start, `tgt_rst_o` is high for at least RST_PULSE_CLKS host clocks, and `tgt_sck_o` stays low whenever `tgt_rst_o` is high.
- R3: At least PWRUP_CLKS host clocks pass between the falling edge of `tgt_rst_o` and the next rising edge of SCK.
- R4: Every SCK high phase lasts exactly HALF_CLKS host clocks. MOSI changes only while SCK is low. Bits go out MSB first, and MISO is sampled at each rising edge of SCK.
- R5: The enable frame is 0xAC 0x53 0x00 0x00. It succeeds only if the byte received during the third byte equals 0x53.
- R6: When the echo is wrong, the whole frame is still sent, `retries_o` goes up by one, and the reset pulse and power-up wait are repeated. After MAX_TRIES failures, `err_o` and `done_o` both rise and SCK stays still.
- R7: The frame 0x4D 0x00 A[23:16] 0x00 is sent before the first page. It is sent again only before a page whose A[23:16] differs from the last value sent. A is a 24-bit word address.
- R8: Each word at address A produces 0x40 0x00 A[7:0] low-byte, then 0x48 0x00 A[7:0] high-byte. Addresses run consecutively from `page_base_i`.
- R9: `wd_ready_o` is high only while no frame is in flight. While it is high, SCK does not toggle.
- R10: A page is committed after `page_words_i` words, or after the last word, whichever comes first. The commit frame is 0x4C P[15:8] P[7:0] 0x00, where P is the page's first word address.
- R11: In poll mode, only 0xF0 0x00 0x00 0x00 frames follow a commit, until bit 0 of the fourth received byte is 0.
- R12: In wait mode, at least WAIT_PAGE_CLKS host clocks pass between the last SCK fall of a commit frame and the next SCK rise, or the rise of `done_o`.
- R13: `done_o` rises when the session ends, and `done_o`, `err_o` and `retries_o` hold until the next start. A start pulse during a session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a session (taken when idle or finished) |
| poll_mode_i | input | 1 | 1: poll status after a commit, 0: fixed wait |
| page_base_i | input | 24 | Word address of the first word |
| page_words_i | input | PSIZE_W | Words per page (at least 1) |
| wd_valid_i | input | 1 | Word stream valid |
| wd_data_i | input | 16 | Word stream data |
| wd_last_i | input | 1 | Marks the final word |
| wd_ready_o | output | 1 | Word stream ready |
| tgt_rst_o | output | 1 | Target reset line |
| tgt_sck_o | output | 1 | Serial clock to target |
| tgt_mosi_o | output | 1 | Serial data to target |
| tgt_miso_i | input | 1 | Serial data from target |
| done_o | output | 1 | Session finished (held) |
| err_o | output | 1 | Enable never succeeded (held) |
| retries_o | output | RETRY_W | Failed enable attempts |

## Verification
The bench builds the block with a 2-clock SCK half period, a 3-clock reset pulse, a 20-clock power-up delay, a 40-clock page wait and a limit of 3 tries. This keeps each session to a few thousand clocks.

It sweeps page sizes 1 to 4 against stream lengths of 1 to 5 words, alternating poll and wait modes. It also uses a base just below a 64K-word boundary, so the extended address frame must be sent twice. A behavioural target model echoes bytes, corrupts the echo on demand, and reports busy twice after each commit. This exercises successful retries, the give-up path and partial last pages.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int WADDR_W = 24;

  localparam logic [7:0] OP_ENABLE = 8'hAC;
  localparam logic [7:0] ECHO_BYTE = 8'h53;
  localparam logic [7:0] OP_EXTADR = 8'h4D;
  localparam logic [7:0] OP_LD_LO  = 8'h40;
  localparam logic [7:0] OP_LD_HI  = 8'h48;
  localparam logic [7:0] OP_COMMIT = 8'h4C;
  localparam logic [7:0] OP_POLL   = 8'hF0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RSTHI, ST_PWR, ST_EN, ST_PAGE, ST_EXT, ST_FETCH,
    ST_LO, ST_HI, ST_COMMIT, ST_POLL, ST_WAIT, ST_FIN
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/isp_frame_shifter.sv
module isp_frame_shifter #(
  parameter int HALF_CLKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic [31:0] frame_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  byte3_o,
  output logic        bit0_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CLKS - 1);

  logic          busy_q, hi_q, sck_q, done_q;
  logic [HW-1:0] cnt_q;
  logic [4:0]    bit_q;
  logic [31:0]   tx_q;
  logic [15:0]   rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          tx_q   <= frame_i;
          hi_q   <= 1'b0;
          cnt_q  <= '0;
          bit_q  <= '0;
        end
      end else if (cnt_q == HALF_LAST) begin
        cnt_q <= '0;
        if (!hi_q) begin
          sck_q <= 1'b1;
          hi_q  <= 1'b1;
          rx_q  <= {rx_q[14:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          hi_q  <= 1'b0;
          if (bit_q == 5'd31) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 5'd1;
            tx_q  <= {tx_q[30:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + HW'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign byte3_o = rx_q[15:8];
  assign bit0_o  = rx_q[0];
  assign sck_o   = sck_q;
  assign mosi_o  = busy_q ? tx_q[31] : 1'b0;

  // R4: clock rests low outside a frame
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  // R4: data line holds while clock is high
  a_r4_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o));
  // R4: a frame ends on a falling edge
  a_r4_done_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !sck_q);
endmodule

// File: rtl/isp_delay_timer.sv
module isp_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
  import isp_pkg::*;
#(
  parameter int HALF_CLKS      = 8,
  parameter int RST_PULSE_CLKS = 4,
  parameter int PWRUP_CLKS     = 400000,
  parameter int WAIT_PAGE_CLKS = 90000,
  parameter int MAX_TRIES      = 4,
  parameter int PSIZE_W        = 9,
  localparam int RETRY_W       = $clog2(MAX_TRIES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                poll_mode_i,
  input  logic [WADDR_W-1:0]  page_base_i,
  input  logic [PSIZE_W-1:0]  page_words_i,
  input  logic                wd_valid_i,
  input  logic [15:0]         wd_data_i,
  input  logic                wd_last_i,
  output logic                wd_ready_o,
  output logic                tgt_rst_o,
  output logic                tgt_sck_o,
  output logic                tgt_mosi_o,
  input  logic                tgt_miso_i,
  output logic                done_o,
  output logic                err_o,
  output logic [RETRY_W-1:0]  retries_o
);
  localparam int TMR_MAX = imax(imax(RST_PULSE_CLKS, PWRUP_CLKS), WAIT_PAGE_CLKS);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [RETRY_W-1:0] LAST_TRY = RETRY_W'(MAX_TRIES - 1);

  seq_state_t state_q, state_n;

  logic               launched_q, sh_go, sh_busy, sh_done, sh_bit0;
  logic [7:0]         sh_byte3;
  logic [31:0]        frame;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_len;
  logic               is_send, accept_start, word_take, page_end;

  logic [WADDR_W-1:0] page_q, cur_q;
  logic [PSIZE_W-1:0] psize_q, widx_q;
  logic [15:0]        word_q;
  logic               last_q, poll_q, ext_vld_q, done_q, err_q;
  logic [7:0]         ext_q;
  logic [RETRY_W-1:0] retries_q;

  isp_frame_shifter #(.HALF_CLKS(HALF_CLKS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (sh_go),
    .frame_i (frame),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .byte3_o (sh_byte3),
    .bit0_o  (sh_bit0),
    .sck_o   (tgt_sck_o),
    .mosi_o  (tgt_mosi_o),
    .miso_i  (tgt_miso_i)
  );

  isp_delay_timer #(.CNT_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  assign is_send = (state_q == ST_EN) || (state_q == ST_EXT) || (state_q == ST_LO) ||
                   (state_q == ST_HI) || (state_q == ST_COMMIT) || (state_q == ST_POLL);
  assign sh_go        = is_send && !launched_q && !sh_busy;
  assign accept_start = start_i && ((state_q == ST_IDLE) || (state_q == ST_FIN));
  assign word_take    = (state_q == ST_FETCH) && wd_valid_i;
  assign page_end     = last_q || (widx_q == psize_q - PSIZE_W'(1));

  always_comb begin
    frame = 32'h0;
    case (state_q)
      ST_EN:     frame = {OP_ENABLE, ECHO_BYTE, 16'h0000};
      ST_EXT:    frame = {OP_EXTADR, 8'h00, page_q[23:16], 8'h00};
      ST_LO:     frame = {OP_LD_LO, 8'h00, cur_q[7:0], word_q[7:0]};
      ST_HI:     frame = {OP_LD_HI, 8'h00, cur_q[7:0], word_q[15:8]};
      ST_COMMIT: frame = {OP_COMMIT, page_q[15:8], page_q[7:0], 8'h00};
      ST_POLL:   frame = {OP_POLL, 24'h000000};
      default:   frame = 32'h0;
    endcase
  end

  always_comb begin
    state_n  = state_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start_i) begin
          state_n  = ST_RSTHI;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(RST_PULSE_CLKS);
        end
      end
      ST_RSTHI: begin
        if (tmr_zero) begin
          state_n  = ST_PWR;
          tmr_load = 1'b1;
          tmr_len  = TMR_W'(PWRUP_CLKS);
        end
      end
      ST_PWR:   if (tmr_zero) state_n = ST_EN;
      ST_EN: begin
        if (sh_done) begin
          if (sh_byte3 == ECHO_BYTE) begin
            state_n = ST_PAGE;
          end else if (retries_q == LAST_TRY) begin
            state_n = ST_FIN;
          end else begin
            state_n  = ST_RSTHI;
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(RST_PULSE_CLKS);
          end
        end
      end
      ST_PAGE: begin
        if (!ext_vld_q || (ext_q != page_q[23:16])) state_n = ST_EXT;
        else                                        state_n = ST_FETCH;
      end
      ST_EXT:   if (sh_done) state_n = ST_FETCH;
      ST_FETCH: if (wd_valid_i) state_n = ST_LO;
      ST_LO:    if (sh_done) state_n = ST_HI;
      ST_HI:    if (sh_done) state_n = page_end ? ST_COMMIT : ST_FETCH;
      ST_COMMIT: begin
        if (sh_done) begin
          if (poll_q) begin
            state_n = ST_POLL;
          end else begin
            state_n  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(WAIT_PAGE_CLKS);
          end
        end
      end
      ST_POLL:  if (sh_done && !sh_bit0) state_n = last_q ? ST_FIN : ST_PAGE;
      ST_WAIT:  if (tmr_zero) state_n = last_q ? ST_FIN : ST_PAGE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      launched_q <= 1'b0;
      page_q     <= '0;
      cur_q      <= '0;
      psize_q    <= '0;
      widx_q     <= '0;
      word_q     <= '0;
      last_q     <= 1'b0;
      poll_q     <= 1'b0;
      ext_vld_q  <= 1'b0;
      ext_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      retries_q  <= '0;
    end else begin
      state_q <= state_n;
      if (sh_done)    launched_q <= 1'b0;
      else if (sh_go) launched_q <= 1'b1;

      if (accept_start) begin
        page_q    <= page_base_i;
        cur_q     <= page_base_i;
        psize_q   <= page_words_i;
        poll_q    <= poll_mode_i;
        widx_q    <= '0;
        last_q    <= 1'b0;
        ext_vld_q <= 1'b0;
        done_q    <= 1'b0;
        err_q     <= 1'b0;
        retries_q <= '0;
      end

      if ((state_q == ST_EN) && sh_done && (sh_byte3 != ECHO_BYTE)) begin
        retries_q <= retries_q + RETRY_W'(1);
        if (retries_q == LAST_TRY) err_q <= 1'b1;
      end

      if ((state_q == ST_EXT) && sh_done) begin
        ext_vld_q <= 1'b1;
        ext_q     <= page_q[23:16];
      end

      if (word_take) begin
        word_q <= wd_data_i;
        last_q <= wd_last_i;
      end

      if ((state_q == ST_HI) && sh_done) begin
        cur_q  <= cur_q + WADDR_W'(1);
        widx_q <= page_end ? '0 : widx_q + PSIZE_W'(1);
      end

      if ((state_n == ST_PAGE) && (state_q != ST_EN)) page_q <= cur_q;

      if ((state_n == ST_FIN) && (state_q != ST_FIN)) done_q <= 1'b1;
    end
  end

  assign wd_ready_o = (state_q == ST_FETCH);
  assign tgt_rst_o  = (state_q == ST_RSTHI);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign retries_o  = retries_q;

  // R2: clock held low while reset line is high
  a_r2_sck_low_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_o |-> !tgt_sck_o);
  // R9: stream accepted only with the link idle
  a_r9_ready_link_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready_o |-> !sh_busy);
  // R6: error only ever reported together with done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  // R6: retry count never passes the limit
  a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retries_o <= RETRY_W'(MAX_TRIES));
  // R13: done holds until a new start
  a_r13_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // R11: status frames only in poll mode
  a_r11_poll_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> poll_q);
endmodule

// File: tb/tb_isp_host_seq.sv
module tb_isp_host_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int RSTC  = 3;
  localparam int PWRC  = 20;
  localparam int WAITC = 40;
  localparam int MAXT  = 3;
  localparam int PSW   = 4;
  localparam int RW    = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, poll_i = 1'b0;
  logic [23:0] base_i = '0;
  logic [PSW-1:0] pw_i = '0;
  logic wd_valid = 1'b0, wd_last = 1'b0;
  logic [15:0] wd_data = '0;
  logic wd_ready, tgt_rst, tgt_sck, tgt_mosi, tgt_miso, done, err;
  logic [RW-1:0] retries;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_host_seq #(.HALF_CLKS(HALF), .RST_PULSE_CLKS(RSTC), .PWRUP_CLKS(PWRC),
    .WAIT_PAGE_CLKS(WAITC), .MAX_TRIES(MAXT), .PSIZE_W(PSW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_mode_i(poll_i),
    .page_base_i(base_i), .page_words_i(pw_i), .wd_valid_i(wd_valid),
    .wd_data_i(wd_data), .wd_last_i(wd_last), .wd_ready_o(wd_ready),
    .tgt_rst_o(tgt_rst), .tgt_sck_o(tgt_sck), .tgt_mosi_o(tgt_mosi),
    .tgt_miso_i(tgt_miso), .done_o(done), .err_o(err), .retries_o(retries));

  // run configuration, written by the stimulus only
  logic [23:0] r_base;
  int r_psz, r_nw, r_desync;
  bit r_poll;
  logic [15:0] words [0:63];

  // monitor-owned state
  int mon_checks = 0, mon_fails = 0;
  int cyc = 0;
  bit run_on = 0, sck_p = 0, rst_p = 0, mosi_p = 0, done_p = 0;
  int rst_len = 0, hi_len = 0, rst_fall_cyc = 0, last_fall = 0;
  bit pwr_arm = 0, gap_arm = 0, lo_pend = 0;
  int bitc = 0, nbyte = 0;
  logic [7:0] shin = 0, out_sh = 0, cur_ext = 0;
  logic [7:0] fb [0:3];
  logic miso_r = 1'b0;
  int desync_left = 0, busy_left = 0;
  int n_enable = 0, n_ext = 0, n_words = 0, n_commit = 0, n_poll = 0, in_page = 0;

  assign tgt_miso = miso_r;

  task automatic mchk(input bit ok, input string what, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_frame();
    logic [23:0] a;
    int exp_in;
    if (fb[0] != 8'hF0 && busy_left > 0)
      mchk(0, "R11 frame other than poll while target busy", fb[0], 8'hF0);
    a = r_base + 24'(n_words);
    case (fb[0])
      8'hAC: begin
        mchk(fb[1] == 8'h53 && fb[2] == 0 && fb[3] == 0, "R5 enable frame bytes", fb[1], 8'h53);
        n_enable++;
        if (desync_left > 0) desync_left--;
      end
      8'h4D: begin
        a = r_base + 24'(n_commit * r_psz);
        mchk(fb[1] == 0 && fb[2] == a[23:16], "R7 extended address byte", fb[2], a[23:16]);
        cur_ext = fb[2];
        n_ext++;
      end
      8'h40: begin
        mchk(fb[1] == 0 && fb[2] == a[7:0], "R8 low load address", fb[2], a[7:0]);
        mchk(fb[3] == words[n_words][7:0], "R8 low data byte", fb[3], words[n_words][7:0]);
        mchk(cur_ext == a[23:16], "R7 extended byte current at load", cur_ext, a[23:16]);
        mchk(!lo_pend, "R8 low load repeated", lo_pend, 0);
        lo_pend = 1;
      end
      8'h48: begin
        mchk(lo_pend, "R8 low byte before high byte", lo_pend, 1);
        mchk(fb[1] == 0 && fb[2] == a[7:0], "R8 high load address", fb[2], a[7:0]);
        mchk(fb[3] == words[n_words][15:8], "R8 high data byte", fb[3], words[n_words][15:8]);
        lo_pend = 0;
        n_words++;
        in_page++;
      end
      8'h4C: begin
        a = r_base + 24'(n_commit * r_psz);
        exp_in = r_nw - n_commit * r_psz;
        if (exp_in > r_psz) exp_in = r_psz;
        mchk({cur_ext, fb[1], fb[2]} == a && fb[3] == 0, "R10 commit page address",
             {fb[1], fb[2]}, a[15:0]);
        mchk(in_page == exp_in, "R10 words in committed page", in_page, exp_in);
        in_page = 0;
        n_commit++;
        if (r_poll) busy_left = 2;
        else gap_arm = 1;
      end
      8'hF0: begin
        mchk(r_poll && fb[1] == 0 && fb[2] == 0 && fb[3] == 0, "R11 poll frame", r_poll, 1);
        n_poll++;
        if (busy_left > 0) busy_left--;
      end
      default: mchk(0, "R8 unexpected opcode", fb[0], 0);
    endcase
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      sck_p = 0; rst_p = 0; run_on = 0; bitc = 0; nbyte = 0; miso_r = 1'b0;
    end else begin
      if (start_i && !run_on) begin
        run_on = 1; desync_left = r_desync; busy_left = 0; gap_arm = 0; pwr_arm = 0;
        n_enable = 0; n_ext = 0; n_words = 0; n_commit = 0; n_poll = 0; in_page = 0;
        lo_pend = 0; cur_ext = 8'hxx; rst_len = 0;
      end
      if (tgt_rst) begin
        if (tgt_sck) mchk(0, "R2 SCK high during reset pulse", 1, 0);
        rst_len++;
        bitc = 0; nbyte = 0; out_sh = 0;
      end
      if (!tgt_rst && rst_p) begin
        mchk(rst_len >= RSTC, "R2 reset pulse width", rst_len, RSTC);
        rst_len = 0; pwr_arm = 1; rst_fall_cyc = cyc;
      end
      if (tgt_sck && !sck_p) begin
        if (wd_ready) mchk(0, "R9 SCK rose while ready high", 1, 0);
        if (done) mchk(0, "R13 SCK active after done", 1, 0);
        if (pwr_arm) begin
          mchk(cyc - rst_fall_cyc >= PWRC, "R3 power-up delay", cyc - rst_fall_cyc, PWRC);
          pwr_arm = 0;
        end
        if (gap_arm) begin
          mchk(cyc - last_fall >= WAITC, "R12 page wait before next frame", cyc - last_fall, WAITC);
          gap_arm = 0;
        end
        hi_len = 1;
        shin = {shin[6:0], tgt_mosi};
        bitc++;
        if (bitc == 8) begin
          fb[nbyte] = shin;
          bitc = 0;
          nbyte++;
          if (nbyte < 4) begin
            if (nbyte == 3 && fb[0] == 8'hF0) out_sh = (busy_left > 0) ? 8'h01 : 8'h00;
            else if (fb[0] == 8'hAC && desync_left > 0) out_sh = ~shin;
            else out_sh = shin;
          end else begin
            do_frame();
            nbyte = 0;
          end
        end
      end else if (tgt_sck) begin
        hi_len++;
        if (tgt_mosi != mosi_p) mchk(0, "R4 MOSI changed while SCK high", tgt_mosi, mosi_p);
      end
      if (!tgt_sck && sck_p) begin
        mchk(hi_len == HALF, "R4 SCK high phase width", hi_len, HALF);
        miso_r = out_sh[7];
        out_sh = {out_sh[6:0], 1'b0};
        last_fall = cyc;
      end
      if (done && !done_p && run_on) begin
        run_on = 0;
        if (gap_arm) begin
          mchk(cyc - last_fall >= WAITC, "R12 page wait before done", cyc - last_fall, WAITC);
          gap_arm = 0;
        end
        mchk(busy_left == 0, "R11 done while target busy", busy_left, 0);
      end
      sck_p = tgt_sck; rst_p = tgt_rst; mosi_p = tgt_mosi; done_p = done;
    end
  end

  // stimulus-owned counters
  int tb_checks = 0, tb_fails = 0;
  bit finished = 0;

  task automatic tchk(input bit ok, input string what, input int act, input int exp);
    tb_checks++;
    if (!ok) begin
      tb_fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] base, input int psz, input int nw, input bit poll,
                     input int desync, input int stall, input bit poke);
    bit exp_err;
    int attempts, pages, exts, prev;
    logic [23:0] pa;
    exp_err  = (desync >= MAXT);
    attempts = exp_err ? MAXT : desync + 1;
    r_base = base; r_psz = psz; r_nw = nw; r_poll = poll; r_desync = desync;
    for (int i = 0; i < nw; i++) words[i] = 16'((i + 1) * 16'h1F3B + nw * 16'h0101 + psz);
    @(negedge clk);
    base_i = base; pw_i = PSW'(psz); poll_i = poll; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!exp_err) begin
      for (int i = 0; i < nw; i++) begin
        repeat (stall) @(negedge clk);
        wd_valid = 1'b1; wd_data = words[i]; wd_last = (i == nw - 1);
        while (!wd_ready) @(negedge clk);
        @(negedge clk);
        wd_valid = 1'b0; wd_last = 1'b0;
        if (poke && i == 0) begin
          start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
      end
    end
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    pages = exp_err ? 0 : (nw + psz - 1) / psz;
    exts = 0; prev = -1;
    for (int p = 0; p < pages; p++) begin
      pa = base + 24'(p * psz);
      if (int'(pa[23:16]) != prev) begin exts++; prev = int'(pa[23:16]); end
    end
    tchk(done == 1'b1, "R13 done held after session", done, 1);
    tchk(err == exp_err, "R6 error flag", err, exp_err);
    tchk(int'(retries) == attempts - (exp_err ? 0 : 1), "R6 retry count", retries,
         attempts - (exp_err ? 0 : 1));
    tchk(n_enable == attempts, "R5 enable attempts", n_enable, attempts);
    tchk(n_words == (exp_err ? 0 : nw), "R9 words accepted", n_words, nw);
    tchk(n_commit == pages, "R10 page commits", n_commit, pages);
    tchk(n_ext == exts, "R7 extended address frames", n_ext, exts);
    tchk(n_poll == (poll ? 3 * pages : 0), "R11 poll frame count", n_poll, poll ? 3 * pages : 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tchk(!done && !err && retries == 0 && !tgt_rst && !tgt_sck && !wd_ready,
         "R1 outputs in reset", {done, err, tgt_rst, tgt_sck, wd_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tchk(!done && !err && retries == 0 && !tgt_rst && !tgt_sck && !wd_ready,
         "R1 outputs after reset", {done, err, tgt_rst, tgt_sck, wd_ready}, 0);
    run(24'h00FFFC, 4, 8, 1'b1, 0, 0, 1'b1);
    run(24'h00FFFC, 4, 7, 1'b0, 2, 3, 1'b0);
    run(24'h000100, 2, 4, 1'b1, 3, 0, 1'b0);
    tchk(!tgt_sck && !tgt_rst, "R6 link quiet after give-up", tgt_sck, 0);
    for (int ps = 1; ps <= 4; ps++)
      for (int nw = 1; nw <= 5; nw++)
        run(24'h020000 + 24'(ps * 16), ps, nw, ((ps + nw) % 2) == 1, nw % 2, nw % 3, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", tb_checks + mon_checks, tb_fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", tb_checks + mon_checks + 1,
               tb_fails + mon_fails + 1);
      $finish;
    end
  end
endmodule